// File: doc/BRIEF.md
# Overlay Window Command Sequencer

This block is a bus master that carries a single command into a non-volatile memory. The memory exposes its command interface as a small window of memory-mapped registers. A host pulses `start` with a command code, a data word, a target address and a parameter word. For buffered program commands, the parameter word also gives the length of a stream of buffer words. The sequencer then owns the bus until the command is finished.

Each command runs in five phases:

- **Window open.** Two writes to the memory controller's mode registers open the register window.
- **Command setup.** The command registers are written in a fixed order.
- **Buffer fill.** Only for buffered commands, the program-buffer pointer is read back and the buffer words are written from that location.
- **Execute and poll.** An execute write starts the command. The status register is then polled until its ready bit is set, or until a poll budget runs out.
- **Window close.** Two more controller writes close the window.

A one-cycle `done` pulse ends the command. `error` reports a poll timeout.

The bus is a single-beat valid/ready port with one transaction in flight. The `stacked` input selects a 32-bit bus built from two 16-bit devices. In that mode the register stride doubles, each register write is repeated for the upper device at address plus 2, and both halves of the status must be ready.

Top module: `ow_cmd_seq`

## Requirements
- R1: After reset, `busy`, `done`, `error` and `m_valid` are 0 and no bus transaction is issued until `start`.
- R2: A command begins with two controller writes (`m_ctl`=1). The first goes to byte offset 0x50 with value 0x00008018, or 0x80000018 when stacked. The second goes to offset 0x40 with value 0x01.
- R3: In 16-bit mode the bus width is 2 bytes and each window register sits at byte address word-offset times 2. Six window writes follow in this order:
  - code at offset 0x40;
  - data[15:0] at offset 0x42;
  - addr[15:0] at offset 0x44;
  - addr[31:16] at offset 0x45;
  - param[15:0] at offset 0x48;
  - param[31:16] at offset 0x49.

  Each value is zero-extended to 32 bits.
- R4: In stacked mode the bus width is 4 bytes. The six writes go to offset times 4 in the R3 order. All six are then repeated at offset times 4 plus 2, and the repeated data write carries data[31:16].
- R5: For codes 0xE9 and 0xEA only, the setup writes are followed by a read of offset 0x08 (the pointer). Then param[15:0] writes follow, to window base + pointer + i for i = 0, 1, ... The writes carry the buffer words in arrival order, and `buf_ready` accepts each one. A count of 0 gives the pointer read and no buffer writes. Any other code gives neither.
- R6: Execution is a write of 0x0001 to offset 0x60, repeated at plus 2 when stacked.
- R7: Status is read at offset 0x66 until bit 7 is set. When stacked, each poll reads both offset 0x66 and offset 0x66 plus 2. The word is rebuilt as (second read << 16) | first read, and the poll succeeds only when (word & 0x00800080) equals 0x00800080.
- R8: If `POLL_LIMIT` polls fail, `error` is set and the window-close sequence still follows. `error` stays set until the next accepted `start`.
- R9: The command ends with a controller write of value 0x8018 (or 0x80000018) to offset 0x50, then a write of 0x02 to offset 0x40. `done` then pulses for one cycle while `busy` falls.
- R10: While `m_valid` is high and `m_ready` low, `m_valid`, `m_write`, `m_ctl`, `m_addr` and `m_wdata` hold steady.
- R11: `start` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a command (taken only when idle) |
| stacked | input | 1 | 1: two stacked 16-bit devices on a 32-bit bus |
| cmd_code | input | 8 | Command code |
| cmd_data | input | 32 | Data word |
| cmd_addr | input | 32 | Target address |
| cmd_param | input | 32 | Parameter word; low half is the buffer word count |
| buf_valid | input | 1 | Buffer word available |
| buf_data | input | 16 | Buffer word |
| buf_ready | output | 1 | Buffer word consumed this cycle |
| m_valid | output | 1 | Bus request |
| m_write | output | 1 | 1 write, 0 read |
| m_ctl | output | 1 | 1: controller register space, 0: window space |
| m_addr | output | AW | Byte address |
| m_wdata | output | 32 | Write data |
| m_ready | input | 1 | Bus accepts request (read data valid same cycle) |
| m_rdata | input | 32 | Read data |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Poll timeout occurred |

## Verification
Two situations are hard to reach from the ports. The first is a stacked poll in which only one half reports ready. The second is a status that never becomes ready.

The bench's bus responder keeps a separate read count for each status address and a ready threshold for each half. This lets it return lower-ready and upper-not-ready on the first poll pair. For the timeout case it uses an unreachable threshold with a reduced poll limit, and counts that exactly that many polls occur before the close sequence.

// File: rtl/ow_cmd_seq.sv
module ow_cmd_seq #(
  parameter int AW = 32,
  parameter logic [31:0] WIN_BASE = 32'h0,
  parameter logic [31:0] CTL_CFG = 32'h50,
  parameter logic [31:0] CTL_DAT = 32'h40,
  parameter int POLL_LIMIT = 1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          stacked,
  input  logic [7:0]    cmd_code,
  input  logic [31:0]   cmd_data,
  input  logic [31:0]   cmd_addr,
  input  logic [31:0]   cmd_param,
  input  logic          buf_valid,
  input  logic [15:0]   buf_data,
  output logic          buf_ready,
  output logic          m_valid,
  output logic          m_write,
  output logic          m_ctl,
  output logic [AW-1:0] m_addr,
  output logic [31:0]   m_wdata,
  input  logic          m_ready,
  input  logic [31:0]   m_rdata,
  output logic          busy,
  output logic          done,
  output logic          error
);
  localparam int PW = $clog2(POLL_LIMIT + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_EN0, S_EN1, S_REG, S_PTR, S_FILL, S_EXE, S_POLL, S_DIS0, S_DIS1, S_FIN
  } st_t;

  st_t st;
  logic [2:0] idx;
  logic half, stk;
  logic [7:0] code;
  logic [31:0] data, addr, par;
  logic [15:0] cnt, lo;
  logic [PW-1:0] pcnt;
  logic [AW-1:0] ptr;
  logic [7:0] woff;
  logic [15:0] rval;
  logic [AW-1:0] win_addr;

  wire is_buf = (code == 8'hE9) || (code == 8'hEA);
  wire acc = m_valid && m_ready;
  wire [31:0] cfg_val = stk ? 32'h8000_0018 : 32'h0000_8018;
  wire poll_ok = stk ? (lo[7] && m_rdata[7]) : m_rdata[7];

  always_comb begin
    case (idx)
      3'd0: woff = 8'h40;
      3'd1: woff = 8'h42;
      3'd2: woff = 8'h44;
      3'd3: woff = 8'h45;
      3'd4: woff = 8'h48;
      default: woff = 8'h49;
    endcase
    if (st == S_PTR) woff = 8'h08;
    else if (st == S_EXE) woff = 8'h60;
    else if (st == S_POLL) woff = 8'h66;
    case (idx)
      3'd0: rval = {8'h00, code};
      3'd1: rval = half ? data[31:16] : data[15:0];
      3'd2: rval = addr[15:0];
      3'd3: rval = addr[31:16];
      3'd4: rval = par[15:0];
      default: rval = par[31:16];
    endcase
  end

  assign win_addr = AW'(WIN_BASE) + (AW'(woff) << (stk ? 2 : 1)) + (half ? AW'(2) : AW'(0));

  always_comb begin
    m_addr = win_addr;
    m_wdata = 32'h0;
    case (st)
      S_EN0, S_DIS0: begin m_addr = AW'(CTL_CFG); m_wdata = cfg_val; end
      S_EN1:  begin m_addr = AW'(CTL_DAT); m_wdata = 32'h1; end
      S_DIS1: begin m_addr = AW'(CTL_DAT); m_wdata = 32'h2; end
      S_REG:  m_wdata = {16'h0, rval};
      S_FILL: begin m_addr = AW'(WIN_BASE) + ptr + AW'(cnt); m_wdata = {16'h0, buf_data}; end
      S_EXE:  m_wdata = 32'h1;
      default: ;
    endcase
  end

  assign m_valid = (st != S_IDLE) && (st != S_FIN) && ((st != S_FILL) || buf_valid);
  assign m_write = (st != S_PTR) && (st != S_POLL);
  assign m_ctl = (st == S_EN0) || (st == S_EN1) || (st == S_DIS0) || (st == S_DIS1);
  assign buf_ready = (st == S_FILL) && acc;
  assign busy = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; idx <= '0; half <= 1'b0; stk <= 1'b0;
      code <= '0; data <= '0; addr <= '0; par <= '0;
      cnt <= '0; lo <= '0; pcnt <= '0; ptr <= '0;
      done <= 1'b0; error <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          code <= cmd_code; data <= cmd_data; addr <= cmd_addr; par <= cmd_param;
          stk <= stacked; error <= 1'b0; idx <= '0; half <= 1'b0; st <= S_EN0;
        end
        S_EN0: if (acc) st <= S_EN1;
        S_EN1: if (acc) st <= S_REG;
        S_REG: if (acc) begin
          if (idx == 3'd5) begin
            idx <= '0;
            if (stk && !half) half <= 1'b1;
            else begin half <= 1'b0; st <= is_buf ? S_PTR : S_EXE; end
          end else idx <= idx + 3'd1;
        end
        S_PTR: if (acc) begin
          ptr <= m_rdata[AW-1:0]; cnt <= '0;
          st <= (par[15:0] == 16'h0) ? S_EXE : S_FILL;
        end
        S_FILL: if (acc) begin
          if (cnt == par[15:0] - 16'd1) begin cnt <= '0; st <= S_EXE; end
          else cnt <= cnt + 16'd1;
        end
        S_EXE: if (acc) begin
          if (stk && !half) half <= 1'b1;
          else begin half <= 1'b0; pcnt <= '0; st <= S_POLL; end
        end
        S_POLL: if (acc) begin
          if (stk && !half) begin lo <= m_rdata[15:0]; half <= 1'b1; end
          else begin
            half <= 1'b0;
            if (poll_ok) st <= S_DIS0;
            else if (pcnt == PW'(POLL_LIMIT - 1)) begin error <= 1'b1; st <= S_DIS0; end
            else pcnt <= pcnt + 1'b1;
          end
        end
        S_DIS0: if (acc) st <= S_DIS1;
        S_DIS1: if (acc) st <= S_FIN;
        default: begin done <= 1'b1; st <= S_IDLE; end
      endcase
    end
  end
endmodule

// File: rtl/ow_cmd_seq_chk.sv
module ow_cmd_seq_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          buf_ready,
  input logic          m_valid,
  input logic          m_write,
  input logic          m_ctl,
  input logic [AW-1:0] m_addr,
  input logic [31:0]   m_wdata,
  input logic          m_ready,
  input logic          busy,
  input logic          done,
  input logic          error
);
  p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !m_valid);

  p_hold_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_addr) && $stable(m_wdata)
                               && $stable(m_write) && $stable(m_ctl)));

  p_buf_on_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    buf_ready |-> (m_valid && m_ready && m_write && !m_ctl));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_not_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_err_in_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(error) |-> busy);

  p_busy_kept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !m_ctl) |=> busy);
endmodule

bind ow_cmd_seq ow_cmd_seq_chk #(.AW(AW)) u_chk (.*);

// File: tb/tb_ow_cmd_seq.sv
`timescale 1ns/1ps
module tb_ow_cmd_seq;
  localparam int AW = 32;
  localparam int PL = 5;

  logic clk = 0, rst_n = 0, start = 0, stacked = 0;
  logic [7:0] cmd_code = 0;
  logic [31:0] cmd_data = 0, cmd_addr = 0, cmd_param = 0;
  logic buf_valid, buf_ready;
  logic [15:0] buf_data;
  logic m_valid, m_write, m_ctl, m_ready = 0;
  logic [AW-1:0] m_addr;
  logic [31:0] m_wdata, m_rdata;
  logic busy, done, error;

  always #4 clk = ~clk;

  ow_cmd_seq #(.AW(AW), .POLL_LIMIT(PL)) dut (.*);

  int total = 0, bad = 0, cycles = 0;
  int nlog = 0, nlo = 0, nhi = 0, bidx = 0;
  int rdy_lo = 0, rdy_hi = 0, bw = 2;
  logic [31:0] ptr_val = 32'h100;
  logic lsel[64], lwr[64];
  logic [31:0] laddr[64], ldat[64];
  logic [15:0] bmem[8];

  assign buf_valid = 1'b1;
  assign buf_data = bmem[bidx[2:0]];

  wire [31:0] a_slo = 32'h66 * bw;
  wire [31:0] a_shi = 32'h66 * bw + 2;
  assign m_rdata = (m_addr == 32'h08 * bw) ? ptr_val :
                   (m_addr == a_slo) ? ((nlo >= rdy_lo) ? 32'hFFFF_0080 : 32'hFFFF_0000) :
                   (m_addr == a_shi) ? ((nhi >= rdy_hi) ? 32'h0000_0080 : 32'h0) : 32'h0;

  always @(posedge clk) begin
    if (m_valid && m_ready) begin
      if (nlog < 64) begin
        lsel[nlog] <= m_ctl; lwr[nlog] <= m_write; laddr[nlog] <= m_addr; ldat[nlog] <= m_wdata;
      end
      nlog <= nlog + 1;
      if (!m_write && m_addr == a_slo) nlo <= nlo + 1;
      if (!m_write && m_addr == a_shi && bw == 4) nhi <= nhi + 1;
      if (buf_ready) bidx <= bidx + 1;
      m_ready <= 1'b0;
    end else if (m_valid) m_ready <= 1'b1;
    else m_ready <= 1'b0;
  end

  task automatic summary;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      total++; bad++;
      $display("FAIL watchdog: run hung");
      summary();
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_tx(string tag, int i, logic sel, logic wr, logic [31:0] a, logic [31:0] d);
    chk({tag, " sel"}, {31'b0, lsel[i]}, {31'b0, sel});
    chk({tag, " wr"}, {31'b0, lwr[i]}, {31'b0, wr});
    chk({tag, " addr"}, laddr[i], a);
    if (wr) chk({tag, " data"}, ldat[i], d);
  endtask

  task automatic prep(int lo_t, int hi_t, logic s);
    @(negedge clk);
    nlog = 0; nlo = 0; nhi = 0; bidx = 0;
    rdy_lo = lo_t; rdy_hi = hi_t; stacked = s; bw = s ? 4 : 2;
  endtask

  task automatic run(logic [7:0] c, logic [31:0] d, logic [31:0] a, logic [31:0] p);
    cmd_code = c; cmd_data = d; cmd_addr = a; cmd_param = p;
    start = 1; @(negedge clk); start = 0;
    for (int k = 0; k < 3000 && !done; k++) @(negedge clk);
    chk("R9 done pulse seen", {31'b0, done}, 32'h1);
    chk("R9 busy low at done", {31'b0, busy}, 32'h0);
    @(negedge clk);
    chk("R9 done one cycle", {31'b0, done}, 32'h0);
  endtask

  task automatic chk_open_setup(string t, logic [7:0] c, logic [31:0] d, logic [31:0] a, logic [31:0] p);
    logic [31:0] cfg = (bw == 4) ? 32'h8000_0018 : 32'h8018;
    logic [7:0] offs[6] = '{8'h40, 8'h42, 8'h44, 8'h45, 8'h48, 8'h49};
    logic [31:0] vals[6];
    vals = '{{24'b0, c}, {16'b0, d[15:0]}, {16'b0, a[15:0]}, {16'b0, a[31:16]},
             {16'b0, p[15:0]}, {16'b0, p[31:16]}};
    chk_tx({t, " R2 cfg"}, 0, 1, 1, 32'h50, cfg);
    chk_tx({t, " R2 dat"}, 1, 1, 1, 32'h40, 32'h1);
    for (int i = 0; i < 6; i++) chk_tx({t, " R3 reg"}, 2 + i, 0, 1, offs[i] * bw, vals[i]);
    if (bw == 4) begin
      vals[1] = {16'b0, d[31:16]};
      for (int i = 0; i < 6; i++) chk_tx({t, " R4 reg hi"}, 8 + i, 0, 1, offs[i] * 4 + 2, vals[i]);
    end
  endtask

  task automatic chk_close(string t, int i);
    chk_tx({t, " R9 cfg"}, i, 1, 1, 32'h50, (bw == 4) ? 32'h8000_0018 : 32'h8018);
    chk_tx({t, " R9 dat"}, i + 1, 1, 1, 32'h40, 32'h2);
  endtask

  task automatic t_reset;
    chk("R1 busy", {31'b0, busy}, 0);
    chk("R1 done", {31'b0, done}, 0);
    chk("R1 error", {31'b0, error}, 0);
    chk("R1 m_valid", {31'b0, m_valid}, 0);
    chk("R1 no bus", nlog, 0);
  endtask

  task automatic t_erase16;
    prep(2, 0, 0);
    run(8'h20, 32'h1111_AAAA, 32'h0012_3456, 32'h0007_0009);
    chk("R5 erase count", nlog, 14);
    chk_open_setup("erase", 8'h20, 32'h1111_AAAA, 32'h0012_3456, 32'h0007_0009);
    chk_tx("R6 exec", 8, 0, 1, 32'hC0, 32'h1);
    for (int i = 9; i < 12; i++) chk_tx("R7 poll", i, 0, 0, 32'hCC, 0);
    chk_close("erase", 12);
    chk("R8 no error", {31'b0, error}, 0);
  endtask

  task automatic t_buf16;
    prep(0, 0, 0);
    bmem = '{16'hA001, 16'hB002, 16'hC003, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0};
    run(8'hE9, 32'h0, 32'h0000_0200, 32'h0000_0003);
    chk("R5 buf count", nlog, 16);
    chk_open_setup("bufprog", 8'hE9, 32'h0, 32'h0000_0200, 32'h3);
    chk_tx("R5 ptr read", 8, 0, 0, 32'h10, 0);
    for (int i = 0; i < 3; i++) chk_tx("R5 fill", 9 + i, 0, 1, 32'h100 + i, {16'b0, bmem[i]});
    chk("R5 words taken", bidx, 3);
    chk_tx("R6 exec", 12, 0, 1, 32'hC0, 32'h1);
    chk_tx("R7 poll", 13, 0, 0, 32'hCC, 0);
    chk_close("bufprog", 14);
  endtask

  task automatic t_buf_zero;
    prep(0, 0, 0);
    run(8'hEA, 32'h5, 32'h0, 32'h0);
    chk("R5 zero-count total", nlog, 13);
    chk_tx("R5 zero-count ptr", 8, 0, 0, 32'h10, 0);
    chk_tx("R6 exec after ptr", 9, 0, 1, 32'hC0, 32'h1);
    chk("R5 zero-count no words", bidx, 0);
  endtask

  task automatic t_stack32;
    prep(0, 1, 1);
    run(8'h42, 32'hBEEF_1234, 32'h0A0B_0C0D, 32'h0000_0001);
    chk("R4 stacked count", nlog, 22);
    chk_open_setup("stacked", 8'h42, 32'hBEEF_1234, 32'h0A0B_0C0D, 32'h1);
    chk_tx("R6 exec lo", 14, 0, 1, 32'h180, 32'h1);
    chk_tx("R6 exec hi", 15, 0, 1, 32'h182, 32'h1);
    chk_tx("R7 poll1 lo", 16, 0, 0, 32'h198, 0);
    chk_tx("R7 poll1 hi", 17, 0, 0, 32'h19A, 0);
    chk_tx("R7 poll2 lo", 18, 0, 0, 32'h198, 0);
    chk_tx("R7 poll2 hi", 19, 0, 0, 32'h19A, 0);
    chk_close("stacked", 20);
  endtask

  task automatic t_timeout;
    prep(1000, 0, 0);
    run(8'h61, 32'h0, 32'h4000, 32'h4000);
    chk("R8 error set", {31'b0, error}, 1);
    chk("R8 poll count", nlo, PL);
    chk("R8 total", nlog, 2 + 6 + 1 + PL + 2);
    chk_close("timeout", 9 + PL);
  endtask

  task automatic t_busy_start;
    prep(0, 0, 0);
    cmd_code = 8'h62; cmd_data = 0; cmd_addr = 32'h10; cmd_param = 0;
    start = 1; @(negedge clk); start = 0;
    repeat (6) @(negedge clk);
    chk("R8 error cleared by start", {31'b0, error}, 0);
    cmd_code = 8'h41;
    start = 1; @(negedge clk); start = 0;
    for (int k = 0; k < 3000 && !done; k++) @(negedge clk);
    repeat (20) @(negedge clk);
    chk("R11 single command", nlog, 12);
    chk("R11 code kept", ldat[2], 32'h62);
    chk("R11 idle after", {31'b0, busy}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset();
    t_erase16();
    t_buf16();
    t_buf_zero();
    t_stack32();
    t_timeout();
    t_busy_start();
    summary();
  end
endmodule